// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial bus engine and a small nonvolatile byte array. The engine hands it a start address when a write is addressed. It then passes each received data byte as a one-cycle valid strobe. The block gathers those bytes into a latch of four byte slots that holds one page. The upper address bits pick the page and stay fixed. The two low bits step through the slots and wrap around, so a fifth byte lands back on the first slot that was used.

When the engine reports the stop that ends the write sequence, the block starts a self-timed write cycle. It raises `busy` for exactly `WR_CYCLES` clock cycles. In the first four of those cycles it walks the slots in ascending order and issues one array write for each slot that received data. While `busy` is high, every input from the engine is ignored. A byte write is the same sequence with a single data byte. A stop with no bytes collected starts nothing.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: A data byte is stored at the page taken from `addr_in[6:2]` and the slot given by a low counter that starts at `addr_in[1:0]`. Only the low counter advances by one per byte, modulo 4. The page bits never change within a sequence.
- R3: When more than four bytes arrive before the stop, the slot counter wraps. A later byte replaces the earlier one in the same slot, so the array receives the last byte for each slot.
- R4: No array write is issued before the stop. `mem_we` is only ever high while `busy` is high.
- R5: A stop taken with at least one byte collected raises `busy` on the next cycle. `busy` then stays high for exactly `WR_CYCLES` cycles.
- R6: During the first four busy cycles, busy cycle k writes slot k, at address {page, k}, if that slot received data. Slots that received no data are not written.
- R7: A stop taken with no byte collected leaves `busy` low and issues no write.
- R8: While `busy` is high, `addr_load`, `byte_vld` and `stop` are ignored.
- R9: An `addr_load` outside a write cycle discards all bytes collected since the previous start address.
- R10: After a write cycle ends, the latch is empty. A stop that follows with no new bytes starts no cycle.
- R11: If two inputs are asserted in the same idle cycle, `stop` wins over `addr_load`, and `addr_load` wins over `byte_vld`. The input that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: capture the start address of a write sequence |
| addr_in | input | 7 | Start address; bits 6:2 are the page, bits 1:0 the first slot |
| byte_vld | input | 1 | Strobe: one received data byte on `byte_in` |
| byte_in | input | 8 | Data byte |
| stop | input | 1 | Strobe: the write sequence has ended |
| busy | output | 1 | High for the whole timed write cycle |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that the engine gives each strobe as a single-cycle pulse. They also assume that `WR_CYCLES` is at least the page size, so the slot walk always ends inside the busy window. The stimulus holds every strobe for one cycle, driven on the falling edge. It uses a write cycle of 12 clocks. It drives the priority case of R11 only in a dedicated directed step. The sweep covers every start address with one to six bytes. Directed steps cover empty stops, inputs sent while busy, and a reload of the address before the stop.

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int OFS_W     = 2,
  parameter int WR_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int SLOTS  = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic [SLOTS-1:0]  filled;
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [CNT_W-1:0]  cnt;

  wire              take_stop = !busy && stop;
  wire              take_addr = !busy && !stop && addr_load;
  wire              take_byte = !busy && !stop && !addr_load && byte_vld;
  wire [OFS_W-1:0]  walk      = cnt[OFS_W-1:0];
  wire              in_walk   = cnt < CNT_W'(SLOTS);
  wire              last      = cnt == CNT_W'(WR_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      page   <= '0;
      ofs    <= '0;
      filled <= '0;
    end else if (busy) begin
      if (last) begin
        busy   <= 1'b0;
        cnt    <= '0;
        filled <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (take_stop) begin
      if (|filled) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (take_addr) begin
      page   <= addr_in[ADDR_W-1:OFS_W];
      ofs    <= addr_in[OFS_W-1:0];
      filled <= '0;
    end else if (take_byte) begin
      filled[ofs] <= 1'b1;
      ofs         <= ofs + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) slot_q[ofs] <= byte_in;
  end

  assign mem_we    = busy && in_walk && filled[walk];
  assign mem_addr  = {page, walk};
  assign mem_wdata = slot_q[walk];

  initial if (WR_CYCLES < SLOTS) $error("WR_CYCLES shorter than one page walk");

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R4
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop)); // R5
  AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop && filled == '0) |=> !busy); // R7
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page)); // R8
  AST_WALK_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr[OFS_W-1:0] == OFS_W'($past(mem_addr[OFS_W-1:0]) + 1'b1)); // R6
  AST_BUSY_NO_NEW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(filled) || !busy); // R8
endmodule

// File: tb/test_page_commit_buf.sv
module test_page_commit_buf;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_load = 0, byte_vld = 0, stop = 0;
  logic [6:0] addr_in = '0;
  logic [7:0] byte_in = '0;
  logic busy, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0, failures = 0, we_cnt = 0;
  bit done = 0;
  logic [7:0] shadow [128];
  logic [7:0] expv   [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_commit_buf #(.WR_CYCLES(WRC)) i_page_commit_buf (
    .clk, .rst_n, .addr_load, .addr_in, .byte_vld, .byte_in, .stop,
    .busy, .mem_we, .mem_addr, .mem_wdata);

  always @(posedge clk) if (rst_n && mem_we) begin
    shadow[mem_addr] <= mem_wdata;
    we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_addr(input logic [6:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); byte_vld = 1; byte_in = d;
    @(negedge clk); byte_vld = 0;
  endtask

  task automatic stop_and_measure(output int blen);
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
  endtask

  initial begin
    int blen, w0;
    for (int i = 0; i < 128; i++) begin shadow[i] = '0; expv[i] = '0; end
    #(CLK_PERIOD*2);
    chk("R1 busy", busy, 0);
    chk("R1 mem_we", mem_we, 0);
    @(negedge clk); rst_n = 1;

    for (int a = 0; a < 128; a++) begin
      for (int n = 1; n <= 6; n++) begin
        int wrote;
        pulse_addr(7'(a));
        w0 = we_cnt;
        wrote = 0;
        for (int k = 0; k < n; k++) begin
          logic [7:0] d;
          int pos;
          d = 8'(a*3 + n*17 + k*5);
          pos = (a & 124) | ((a + k) & 3);
          expv[pos] = d;
          pulse_byte(d);
        end
        chk("R4 no write before stop", we_cnt - w0, 0);
        stop_and_measure(blen);
        chk("R5 busy length", blen, WRC);
        wrote = (n > 4) ? 4 : n;
        chk("R6 write count", we_cnt - w0, wrote);
        for (int s = 0; s < 4; s++)
          chk((n > 4) ? "R3 wrap content" : "R2 page content",
              shadow[(a & 124) | s], expv[(a & 124) | s]);
      end
    end

    // R10: stop after a finished cycle with no new bytes
    w0 = we_cnt;
    stop_and_measure(blen);
    chk("R10 no busy", blen, 0);

    // R7: empty stop after a fresh address
    pulse_addr(7'd40);
    stop_and_measure(blen);
    chk("R7 no busy", blen, 0);
    chk("R7 no write", we_cnt - w0, 0);

    // R8: inputs while busy are ignored
    pulse_addr(7'd8);
    pulse_byte(8'hA5); expv[8] = 8'hA5;
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0; addr_load = 1; addr_in = 7'd100;
    @(negedge clk); addr_load = 0; byte_vld = 1; byte_in = 8'h3C;
    @(negedge clk); byte_vld = 0; stop = 1;
    @(negedge clk); stop = 0;
    while (busy) @(negedge clk);
    chk("R8 shadow 100", shadow[100], expv[100]);
    chk("R8 shadow 8", shadow[8], 8'hA5);
    w0 = we_cnt;
    stop_and_measure(blen);
    chk("R8 latched nothing while busy", blen, 0);

    // R9: reload discards collected bytes
    pulse_addr(7'd20);
    pulse_byte(8'h11);
    pulse_byte(8'h22);
    pulse_addr(7'd22);
    pulse_byte(8'h33); expv[22] = 8'h33;
    w0 = we_cnt;
    stop_and_measure(blen);
    chk("R9 write count", we_cnt - w0, 1);
    chk("R9 slot20 kept", shadow[20], expv[20]);
    chk("R9 slot22", shadow[22], 8'h33);

    // R11: priority between coincident strobes
    pulse_addr(7'd60);
    @(negedge clk); addr_load = 1; addr_in = 7'd64; byte_vld = 1; byte_in = 8'h77;
    @(negedge clk); addr_load = 0; byte_vld = 0;
    pulse_byte(8'h44); expv[64] = 8'h44;
    @(negedge clk); stop = 1; byte_vld = 1; byte_in = 8'h99;
    @(negedge clk); stop = 0; byte_vld = 0;
    w0 = we_cnt;
    while (busy) @(negedge clk);
    chk("R11 addr beats byte", shadow[64], 8'h44);
    chk("R11 byte dropped at stop", shadow[65], expv[65]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule